// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The controller watches eight interrupt request lines and drives one interrupt output toward a processor. It also drives a 3-bit vector that names the request it last granted. Each line goes through a two-stage synchronizer. The line is then sensed either on its rising edge or by its level, and the result is recorded in a pending register. Lines that are set in the mask register are kept out of arbitration. Arbitration picks the highest-priority pending line that is not masked. Priority is either fixed, with the lowest index winning, or rotating, with the most recently granted line dropping to the bottom.

The processor grants a request with a one-cycle acknowledge pulse. In that cycle the winner's index is latched onto the vector, its pending bit is cleared and its in-service bit is set. Interrupts nest: the output is raised only when the best unmasked pending line outranks every line still in service. In-service entries are retired in one of three ways:
- an end-of-interrupt command that names an index;
- a command that names no index, which retires the highest-ranked in-service entry;
- automatic retirement at the acknowledge itself.

Configuration uses a small synchronous write port.

Top module: `prio_intc`

## Requirements
- R1: After reset, no line is pending or in service, every line is masked and set to edge sensing, priority is fixed, automatic retirement is off, the vector reads 0 and the interrupt output is low.
- R2: A write with address 0 loads the mask (1 = ignore line). Address 1 loads the sensing mode (1 = level, 0 = edge). Address 2 loads control: bit 0 = rotating priority, bit 1 = automatic retirement. Address 3 issues an end-of-interrupt: bit 3 = 1 retires the index in bits 2:0, and bit 3 = 0 retires the highest-ranked in-service entry. Each write takes effect at the clock edge where it is sampled.
- R3: A masked line is never granted, but its pending bit is kept. Clearing the mask bit later lets the held request through.
- R4: An edge-sensed line becomes pending on a rising edge of its input, three clock edges after the input changes. It stays pending after the input falls, until it is granted. A line that is held high does not become pending again.
- R5: A level-sensed line's pending bit follows its synchronized input, so a request withdrawn before it is granted disappears.
- R6: In fixed mode, the lowest pending unmasked index wins.
- R7: In rotating mode, after line k is granted, line k+1 (mod 8) has the highest priority and the order continues upward from there.
- R8: An acknowledge while the output is high latches the winner onto the vector, clears its pending bit and sets its in-service bit, all at one clock edge. An acknowledge while the output is low changes nothing.
- R9: The interrupt output is high only when an unmasked pending line ranks strictly above every in-service line.
- R10: An end-of-interrupt command with no index clears the highest-ranked in-service bit under the current priority order.
- R11: An end-of-interrupt command with an index clears exactly that in-service bit.
- R12: With automatic retirement on, an acknowledge sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 3 | Index of the most recently granted line |

## Verification
A wrong pending or in-service bit shows up at the ports as an interrupt output that is raised or held back on the cycle after the faulty update. It can also show up as a wrong vector at the next acknowledge. Sweeps over all 255 nonzero request patterns, in fixed and rotating modes, compare every granted vector with a priority computed arithmetically in the bench. A stale rotation pointer therefore shows up by the next grant. Nesting and the retirement styles are probed by raising a line that only a correctly cleared in-service bit would let through, and checking the output one cycle after the command.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [LINES-1:0] cfg_wdata,
  input  logic             ack,
  output logic             irq_out,
  output logic [IW-1:0]    vec_out
);

  logic [LINES-1:0] sync1, sync2, prev, pend, isr, mask, lvl;
  logic             rot_en, auto_eoi;
  logic [IW-1:0]    top_q, idx, win, svc;
  logic             win_ok, svc_ok;

  wire [IW-1:0]    top = rot_en ? top_q : '0;
  wire [LINES-1:0] req = pend & ~mask;

  always_comb begin
    win = '0; win_ok = 1'b0; svc = '0; svc_ok = 1'b0; idx = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      idx = top + IW'(k);
      if (req[idx]) begin win = idx; win_ok = 1'b1; end
      if (isr[idx]) begin svc = idx; svc_ok = 1'b1; end
    end
  end

  wire [IW-1:0] win_rank = IW'(win - top);
  wire [IW-1:0] svc_rank = IW'(svc - top);
  assign irq_out = win_ok && (!svc_ok || win_rank < svc_rank);

  wire             take     = ack && irq_out;
  wire [LINES-1:0] take_vec = take ? (LINES'(1) << win) : '0;
  wire             eoi_wr   = cfg_we && cfg_addr == 2'd3;
  wire [LINES-1:0] eoi_clr  = !eoi_wr        ? '0 :
                              cfg_wdata[IW]  ? (LINES'(1) << cfg_wdata[IW-1:0]) :
                              svc_ok         ? (LINES'(1) << svc) : '0;
  wire [LINES-1:0] rise     = sync2 & ~prev;
  wire [LINES-1:0] pend_n   = (lvl & sync2 & ~take_vec) |
                              (~lvl & ((pend & ~take_vec) | rise));
  wire [LINES-1:0] isr_n    = (isr | (auto_eoi ? '0 : take_vec)) & ~eoi_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; prev <= '0;
      pend <= '0; isr <= '0; mask <= '1; lvl <= '0;
      rot_en <= 1'b0; auto_eoi <= 1'b0; top_q <= '0; vec_out <= '0;
    end else begin
      sync1 <= irq_in;
      sync2 <= sync1;
      prev  <= sync2;
      pend  <= pend_n;
      isr   <= isr_n;
      if (take) begin
        vec_out <= win;
        if (rot_en) top_q <= win + IW'(1);
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: mask <= cfg_wdata;
          2'd1: lvl  <= cfg_wdata;
          2'd2: begin rot_en <= cfg_wdata[0]; auto_eoi <= cfg_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

endmodule

module prio_intc_chk #(
  parameter int LINES = 8,
  localparam int IW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             irq_out,
  input logic [IW-1:0]    vec_out,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [LINES-1:0] pend,
  input logic [LINES-1:0] isr,
  input logic [LINES-1:0] mask,
  input logic [IW-1:0]    win,
  input logic             auto_eoi
);

  wire eoi_cmd = cfg_we && cfg_addr == 2'd3;
  wire ctl_cmd = cfg_we && cfg_addr == 2'd2;

  assert_grant_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> vec_out == $past(win));

  assert_grant_isr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !auto_eoi && !eoi_cmd) |=> (isr[vec_out] && !$past(isr[win])));

  assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !eoi_cmd) |=> ($stable(vec_out) && $stable(isr)));

  assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |-> !mask[win]);

  assert_auto_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && auto_eoi && !eoi_cmd && !ctl_cmd) |=> isr == $past(isr));

  assert_has_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend & ~mask) != '0);

endmodule

bind prio_intc prio_intc_chk #(.LINES(LINES)) chk (.*);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       ack = 1'b0;
  logic       irq_out;
  logic [2:0] vec_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  prio_intc uut (.*);

  always #2.5 clk = ~clk;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step(1);
    ack = 1'b0;
  endtask

  function automatic int pick(logic [7:0] p, int t);
    for (int k = 0; k < 8; k++)
      if (p[(t + k) % 8]) return (t + k) % 8;
    return -1;
  endfunction

  initial begin
    step(1000000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t;
    int w;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 irq_out", irq_out, 0);
    chk("R1 vec_out", vec_out, 0);

    // Fixed-priority sweep, level sensing (R2 R5 R6 R8 R10)
    wr(2'd1, 8'hff);
    wr(2'd0, 8'h00);
    for (int p = 1; p < 256; p++) begin
      irq_in = 8'(p);
      step(3);
      chk("R6 irq_out", irq_out, 1);
      pulse_ack();
      chk("R6 vec", vec_out, pick(8'(p), 0));
      irq_in = '0;
      step(4);
      chk("R9 blocked", irq_out, 0);
      wr(2'd3, 8'h00);
    end

    // Rotating sweep (R7)
    wr(2'd2, 8'h01);
    t = 0;
    for (int p = 1; p < 256; p++) begin
      irq_in = 8'(p);
      step(3);
      chk("R7 irq_out", irq_out, 1);
      pulse_ack();
      w = pick(8'(p), t);
      chk("R7 vec", vec_out, w);
      t = (w + 1) % 8;
      irq_in = '0;
      step(4);
      wr(2'd3, 8'h00);
      chk("R10 cleared", irq_out, 0);
    end

    // Fresh reset for directed cases
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
    chk("R1 irq_out after reset", irq_out, 0);
    irq_in = 8'h01;
    step(3);
    chk("R1 R3 masked at reset", irq_out, 0);
    wr(2'd0, 8'h00);
    chk("R3 held request released", irq_out, 1);
    pulse_ack();
    chk("R8 vec", vec_out, 0);
    chk("R8 output drops", irq_out, 0);
    wr(2'd3, 8'h00);
    step(3);
    chk("R4 held high no retrigger", irq_out, 0);
    irq_in = 8'h00;
    step(3);
    irq_in = 8'h01;
    step(1);
    irq_in = 8'h00;
    step(4);
    chk("R4 short pulse latched", irq_out, 1);
    pulse_ack();
    wr(2'd3, 8'h00);
    step(1);
    chk("R4 cleared by grant", irq_out, 0);

    // R5 level withdrawn before grant
    wr(2'd1, 8'h01);
    irq_in = 8'h01;
    step(3);
    chk("R5 level pending", irq_out, 1);
    irq_in = 8'h00;
    step(3);
    chk("R5 level withdrawn", irq_out, 0);

    // R9 nesting, R10 R11 retirement
    wr(2'd1, 8'hff);
    irq_in = 8'h08;
    step(3);
    pulse_ack();
    chk("R8 vec 3", vec_out, 3);
    irq_in = 8'h28;
    step(3);
    chk("R9 lower blocked", irq_out, 0);
    irq_in = 8'h2a;
    step(3);
    chk("R9 higher nests", irq_out, 1);
    pulse_ack();
    chk("R9 vec 1", vec_out, 1);
    irq_in = 8'h2c;
    step(3);
    chk("R9 blocked by 1", irq_out, 0);
    wr(2'd3, 8'h00);
    chk("R10 highest retired", irq_out, 1);
    pulse_ack();
    chk("R10 vec 2", vec_out, 2);
    step(2);
    wr(2'd3, 8'h0b);
    step(1);
    chk("R11 named index only", irq_out, 0);
    wr(2'd3, 8'h00);
    step(1);
    chk("R11 R10 all retired", irq_out, 1);
    irq_in = 8'h00;
    step(4);
    chk("R5 requests gone", irq_out, 0);

    // R8 ignored acknowledge
    pulse_ack();
    chk("R8 idle ack vec", vec_out, 2);
    chk("R8 idle ack out", irq_out, 0);

    // R12 automatic retirement
    wr(2'd2, 8'h02);
    irq_in = 8'h10;
    step(3);
    pulse_ack();
    chk("R12 vec 4", vec_out, 4);
    step(2);
    chk("R12 nothing in service", irq_out, 1);
    irq_in = 8'h01;
    step(3);
    pulse_ack();
    chk("R12 R6 vec 0", vec_out, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule